// File: doc/BRIEF.md
# DMA Burst Governor with Priority Gating

This block decides when a DMA engine may take a memory bus that it shares with a processor. While a burst runs, the processor is held and cannot fetch or handle interrupts. A burst starts only when three things are true: a channel requests, the programmed DMA priority is not below the processor's current priority level, and the minimum gap since the previous burst has passed. The block then runs a fixed start-up overhead, in which the processor's pending instruction fetch is abandoned. It then issues one transfer strobe per clock, and the selected channel is reported with each strobe. After the last strobe, two trailing clocks pass before the processor is released to fetch the abandoned byte again.

A burst is capped by a programmed byte count, and the channel is chosen again before every byte. Moving to a different channel costs one dead clock with the bus still granted. The gap timer is reloaded when each burst's last byte is moved. A pending interrupt is served only in a clock where no burst is taking the bus, so an eligible DMA request is always served ahead of the interrupt. The balanced setting is 8 bytes per burst with 64 clocks between bursts.

Top module: `dma_burst_governor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bus_grant`, `cpu_hold`, `xfer_strobe`, `fetch_discard`, `cpu_refetch` and `irq_go` are all 0.
- R2: A burst starts only in a cycle where `dma_prio` >= `cpu_prio`, with both read as unsigned levels 0 to 3. Level 3 DMA may therefore start at any time, and level 0 DMA only when the processor is at 0. A burst that has started always runs to its end.
- R3: `irq_go` is 1 exactly when `irq_pending` is 1, no burst is active, and no burst is being started in that same cycle.
- R4: `cpu_hold` and `bus_grant` rise together in the cycle after the start decision. The first strobe comes FETCH_CLKS+3 cycles after that rise. `fetch_discard` is high for the first FETCH_CLKS cycles of every burst.
- R5: Strobes on the same channel occur in consecutive cycles with no idle cycle between them. `chan_sel` gives the channel served by each strobe.
- R6: Every byte, including the first one of a burst, goes to the lowest-index channel whose `chan_req` bit is set.
- R7: When the selected channel changes within a burst, there is exactly one cycle with `bus_grant` high and no strobe. Two back-to-back strobes never differ in `chan_sel`.
- R8: A burst ends after N strobes, or earlier if no channel requests. N is `max_burst` clamped to the range 1..64, so a field value of 0 acts as 1 and any value above 64 acts as 64. The value is taken at the start decision.
- R9: After the last strobe, `bus_grant` falls and `cpu_hold` stays high for 2 more cycles. In the first cycle with `cpu_hold` low, `cpu_refetch` pulses for one cycle.
- R10: The first `cpu_hold` cycle of a burst comes at least G cycles after the previous burst's last strobe cycle. G is `min_gap` clamped to the range 12..512 and taken at that last strobe. If an eligible request is pending throughout, the distance is exactly G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_prio | input | 2 | Processor's current priority level |
| dma_prio | input | 2 | Programmed priority shared by all DMA channels |
| irq_pending | input | 1 | An interrupt is waiting for the processor |
| chan_req | input | NCH | Per-channel transfer request |
| max_burst | input | 7 | Byte limit per burst (clamped to 1..64) |
| min_gap | input | 10 | Minimum clocks between bursts (clamped to 12..512) |
| bus_grant | output | 1 | DMA owns the memory bus |
| cpu_hold | output | 1 | Processor is stalled, including overhead cycles |
| xfer_strobe | output | 1 | One byte moves this cycle |
| chan_sel | output | $clog2(NCH) | Channel served by the current strobe |
| fetch_discard | output | 1 | Processor fetch in progress that will be thrown away |
| cpu_refetch | output | 1 | Processor starts fetching the abandoned byte again |
| irq_go | output | 1 | Processor may take the pending interrupt now |

## Verification
A single channel with a long backlog separates the cap on burst size from the end caused by a drained request. It also shows the exact gap when a request stays pending. Two channels requesting at once, one low and one high, show the lowest-first order and the cost of the dead cycle through the total hold length. Sweeps of the processor and DMA levels, with an interrupt held pending, show that a blocked request stays silent and that the interrupt is deferred exactly in the cycle a burst is taken. Out-of-range values in the length and gap fields, such as 0, 100, 5 and 1000, show the clamping at both ends of each range.

// File: rtl/dma_gov_pkg.sv
package dma_gov_pkg;
  typedef enum logic [2:0] {
    GS_IDLE,
    GS_START,
    GS_XFER,
    GS_DEAD,
    GS_TAIL
  } gov_state_t;
endpackage

// File: rtl/dma_chan_pick.sv
// Fixed-priority pick: lowest set request index wins.
module dma_chan_pick #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           valid,
  output logic [CW-1:0]  idx
);
  logic [CW-1:0] stage [NCH+1];

  assign stage[NCH] = '0;

  genvar g;
  generate
    for (g = NCH - 1; g >= 0; g--) begin : g_chain
      assign stage[g] = req[g] ? CW'(g) : stage[g+1];
    end
  endgenerate

  assign valid = |req;
  assign idx   = stage[0];
endmodule

// File: rtl/dma_gap_timer.sv
// Down-counter that holds off the next burst start.
module dma_gap_timer #(
  parameter int GAP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             gap_ok
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // A start decided while the count is at 1 or 0 puts the first
  // hold cycle exactly one full gap after the last byte.
  assign gap_ok = (cnt <= GAP_W'(1));
endmodule

// File: rtl/dma_burst_seq.sv
// Burst sequencer: start overhead, byte phase, dead cycles, tail.
module dma_burst_seq
  import dma_gov_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int MAXB_W     = 7,
  parameter int FETCH_CLKS = 2,
  parameter int EXTRA_CLKS = 3,
  parameter int TAIL_CLKS  = 2,
  localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int START_CLKS = FETCH_CLKS + EXTRA_CLKS,
  localparam int CNT_W      = $clog2(START_CLKS + TAIL_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prio_ok,
  input  logic              gap_ok,
  input  logic              irq_pending,
  input  logic              pick_valid,
  input  logic [CW-1:0]     pick_idx,
  input  logic [MAXB_W-1:0] burst_lim,
  output logic              gap_load,
  output logic              bus_grant,
  output logic              cpu_hold,
  output logic              xfer_strobe,
  output logic [CW-1:0]     chan_sel,
  output logic              fetch_discard,
  output logic              cpu_refetch,
  output logic              irq_go
);
  gov_state_t        state;
  logic [CNT_W-1:0]  phase_cnt;
  logic [MAXB_W-1:0] byte_cnt;
  logic [MAXB_W-1:0] lim_q;
  logic [CW-1:0]     cur_ch;
  logic              refetch_q;
  logic              start_now;
  logic [MAXB_W-1:0] byte_next;
  logic              last_byte;

  assign start_now = (state == GS_IDLE) && pick_valid && prio_ok && gap_ok;
  assign byte_next = byte_cnt + 1'b1;
  assign last_byte = (byte_next == lim_q) || !pick_valid;
  assign gap_load  = ((state == GS_XFER) && last_byte) ||
                     ((state == GS_START) && (phase_cnt == '0) && !pick_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= GS_IDLE;
      phase_cnt <= '0;
      byte_cnt  <= '0;
      lim_q     <= '0;
      cur_ch    <= '0;
      refetch_q <= 1'b0;
    end else begin
      refetch_q <= (state == GS_TAIL) && (phase_cnt == '0);
      unique case (state)
        GS_IDLE: begin
          if (start_now) begin
            state     <= GS_START;
            phase_cnt <= CNT_W'(START_CLKS - 1);
            lim_q     <= burst_lim;
          end
        end
        GS_START: begin
          if (phase_cnt != '0) begin
            phase_cnt <= phase_cnt - 1'b1;
          end else if (pick_valid) begin
            state    <= GS_XFER;
            cur_ch   <= pick_idx;
            byte_cnt <= '0;
          end else begin
            state     <= GS_TAIL;
            phase_cnt <= CNT_W'(TAIL_CLKS - 1);
          end
        end
        GS_XFER: begin
          byte_cnt <= byte_next;
          if (last_byte) begin
            state     <= GS_TAIL;
            phase_cnt <= CNT_W'(TAIL_CLKS - 1);
          end else if (pick_idx != cur_ch) begin
            state  <= GS_DEAD;
            cur_ch <= pick_idx;
          end
        end
        GS_DEAD: begin
          state <= GS_XFER;
        end
        GS_TAIL: begin
          if (phase_cnt != '0) begin
            phase_cnt <= phase_cnt - 1'b1;
          end else begin
            state <= GS_IDLE;
          end
        end
        default: state <= GS_IDLE;
      endcase
    end
  end

  assign cpu_hold      = (state != GS_IDLE);
  assign bus_grant     = (state == GS_START) || (state == GS_XFER) || (state == GS_DEAD);
  assign xfer_strobe   = (state == GS_XFER);
  assign chan_sel      = cur_ch;
  assign fetch_discard = (state == GS_START) && (phase_cnt >= CNT_W'(EXTRA_CLKS));
  assign cpu_refetch   = refetch_q;
  assign irq_go        = irq_pending && (state == GS_IDLE) && !start_now;
endmodule

// File: rtl/dma_burst_governor.sv
// Top: clamps the programmed fields, gates by priority, ties the parts.
module dma_burst_governor #(
  parameter int NCH        = 4,
  parameter int MAXB_W     = 7,
  parameter int GAP_W      = 10,
  parameter int BURST_MAX  = 64,
  parameter int GAP_MIN    = 12,
  parameter int GAP_MAX    = 512,
  parameter int FETCH_CLKS = 2,
  parameter int EXTRA_CLKS = 3,
  parameter int TAIL_CLKS  = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cpu_prio,
  input  logic [1:0]        dma_prio,
  input  logic              irq_pending,
  input  logic [NCH-1:0]    chan_req,
  input  logic [MAXB_W-1:0] max_burst,
  input  logic [GAP_W-1:0]  min_gap,
  output logic              bus_grant,
  output logic              cpu_hold,
  output logic              xfer_strobe,
  output logic [CW-1:0]     chan_sel,
  output logic              fetch_discard,
  output logic              cpu_refetch,
  output logic              irq_go
);
  localparam logic [MAXB_W-1:0] BMAX_V = MAXB_W'(BURST_MAX);
  localparam logic [GAP_W-1:0]  GMIN_V = GAP_W'(GAP_MIN);
  localparam logic [GAP_W-1:0]  GMAX_V = GAP_W'(GAP_MAX);

  logic [MAXB_W-1:0] burst_lim;
  logic [GAP_W-1:0]  gap_lim;
  logic              prio_ok;
  logic              gap_ok;
  logic              gap_load;
  logic              pick_valid;
  logic [CW-1:0]     pick_idx;

  always_comb begin
    if (max_burst == '0)        burst_lim = MAXB_W'(1);
    else if (max_burst > BMAX_V) burst_lim = BMAX_V;
    else                         burst_lim = max_burst;
  end

  always_comb begin
    if (min_gap < GMIN_V)      gap_lim = GMIN_V;
    else if (min_gap > GMAX_V) gap_lim = GMAX_V;
    else                       gap_lim = min_gap;
  end

  assign prio_ok = (dma_prio >= cpu_prio);

  dma_chan_pick #(.NCH(NCH)) u_pick (
    .req   (chan_req),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  dma_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (gap_load),
    .load_val (gap_lim - 1'b1),
    .gap_ok   (gap_ok)
  );

  dma_burst_seq #(
    .NCH        (NCH),
    .MAXB_W     (MAXB_W),
    .FETCH_CLKS (FETCH_CLKS),
    .EXTRA_CLKS (EXTRA_CLKS),
    .TAIL_CLKS  (TAIL_CLKS)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .prio_ok       (prio_ok),
    .gap_ok        (gap_ok),
    .irq_pending   (irq_pending),
    .pick_valid    (pick_valid),
    .pick_idx      (pick_idx),
    .burst_lim     (burst_lim),
    .gap_load      (gap_load),
    .bus_grant     (bus_grant),
    .cpu_hold      (cpu_hold),
    .xfer_strobe   (xfer_strobe),
    .chan_sel      (chan_sel),
    .fetch_discard (fetch_discard),
    .cpu_refetch   (cpu_refetch),
    .irq_go        (irq_go)
  );
endmodule

// File: rtl/dma_gov_checker.sv
module dma_gov_checker #(
  parameter int NCH       = 4,
  parameter int MAXB_W    = 7,
  parameter int GAP_W     = 10,
  parameter int BURST_MAX = 64,
  parameter int GAP_MIN   = 12,
  parameter int GAP_MAX   = 512,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cpu_prio,
  input logic [1:0]        dma_prio,
  input logic              irq_pending,
  input logic [MAXB_W-1:0] max_burst,
  input logic [GAP_W-1:0]  min_gap,
  input logic              bus_grant,
  input logic              cpu_hold,
  input logic              xfer_strobe,
  input logic [CW-1:0]     chan_sel,
  input logic              cpu_refetch,
  input logic              irq_go
);
  logic [MAXB_W:0] lim_c, lim_r, bytes_seen;
  logic [GAP_W:0]  gmin_c, gmin_r, since;
  logic            seen;

  always_comb begin
    if (max_burst == '0)                 lim_c = (MAXB_W+1)'(1);
    else if (int'(max_burst) > BURST_MAX) lim_c = (MAXB_W+1)'(BURST_MAX);
    else                                  lim_c = {1'b0, max_burst};
    if (int'(min_gap) < GAP_MIN)      gmin_c = (GAP_W+1)'(GAP_MIN);
    else if (int'(min_gap) > GAP_MAX) gmin_c = (GAP_W+1)'(GAP_MAX);
    else                              gmin_c = {1'b0, min_gap};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_r <= '0; bytes_seen <= '0; gmin_r <= '0; since <= '0; seen <= 1'b0;
    end else begin
      if (!cpu_hold) lim_r <= lim_c;
      if (!cpu_hold) bytes_seen <= '0;
      else if (xfer_strobe) bytes_seen <= bytes_seen + 1'b1;
      if (xfer_strobe) begin
        since <= (GAP_W+1)'(1); gmin_r <= gmin_c; seen <= 1'b1;
      end else if (since != '1) begin
        since <= since + 1'b1;
      end
    end
  end

  assert_prio_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_hold) |-> $past(dma_prio >= cpu_prio));
  assert_dma_before_irq_R3: assert property (@(posedge clk) disable iff (rst)
    irq_go |-> (!cpu_hold && irq_pending));
  assert_start_not_irq_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_hold) |-> $past(!irq_go));
  assert_grant_with_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_hold) |-> bus_grant);
  assert_strobe_owned_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe |-> (bus_grant && cpu_hold));
  assert_no_instant_switch_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_strobe && $past(xfer_strobe)) |-> (chan_sel == $past(chan_sel)));
  assert_burst_cap_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe |-> (bytes_seen < lim_r));
  assert_tail_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_grant) |-> (cpu_hold && !xfer_strobe));
  assert_refetch_after_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_refetch |-> (!cpu_hold && $past(cpu_hold)));
  assert_min_gap_R10: assert property (@(posedge clk) disable iff (rst)
    (seen && $rose(cpu_hold)) |-> (since >= gmin_r));
endmodule

bind dma_burst_governor dma_gov_checker #(
  .NCH(NCH), .MAXB_W(MAXB_W), .GAP_W(GAP_W),
  .BURST_MAX(BURST_MAX), .GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)
) u_gov_chk (
  .clk(clk), .rst(rst), .cpu_prio(cpu_prio), .dma_prio(dma_prio),
  .irq_pending(irq_pending), .max_burst(max_burst), .min_gap(min_gap),
  .bus_grant(bus_grant), .cpu_hold(cpu_hold), .xfer_strobe(xfer_strobe),
  .chan_sel(chan_sel), .cpu_refetch(cpu_refetch), .irq_go(irq_go)
);

// File: tb/tb_dma_burst_governor.sv
module tb_dma_burst_governor;
  localparam int NCH   = 4;
  localparam int FETCH = 2;
  localparam int START = FETCH + 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cpu_prio = 2'd0;
  logic [1:0] dma_prio = 2'd2;
  logic       irq_pending = 1'b0;
  logic [NCH-1:0] chan_req;
  logic [6:0] max_burst = 7'd8;
  logic [9:0] min_gap = 10'd64;
  logic bus_grant, cpu_hold, xfer_strobe, fetch_discard, cpu_refetch, irq_go;
  logic [1:0] chan_sel;

  int rem [NCH];
  int exp_ch[$], exp_len[$], exp_gap[$];
  int checks = 0, errors = 0, cyc = 0, rises = 0;
  int run_len = 0, disc = 0, run_strb = 0, last_strb = 0, gap_lat = 0;
  bit seen = 0, hold_prev = 0, done = 0;

  always #2 clk = ~clk;

  dma_burst_governor dut (
    .clk(clk), .rst(rst), .cpu_prio(cpu_prio), .dma_prio(dma_prio),
    .irq_pending(irq_pending), .chan_req(chan_req), .max_burst(max_burst),
    .min_gap(min_gap), .bus_grant(bus_grant), .cpu_hold(cpu_hold),
    .xfer_strobe(xfer_strobe), .chan_sel(chan_sel),
    .fetch_discard(fetch_discard), .cpu_refetch(cpu_refetch), .irq_go(irq_go)
  );

  // Channel engines: request drops as soon as the last byte is being moved.
  always_comb begin
    for (int i = 0; i < NCH; i++)
      chan_req[i] = rem[i] > ((xfer_strobe && int'(chan_sel) == i) ? 1 : 0);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && xfer_strobe && rem[chan_sel] > 0) rem[chan_sel] <= rem[chan_sel] - 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gclamp(input int v);
    return (v < 12) ? 12 : ((v > 512) ? 512 : v);
  endfunction

  task automatic push_burst(input int len, input int gap);
    exp_len.push_back(len);
    exp_gap.push_back(gap);
  endtask

  task automatic push_ch(input int ch, input int n);
    for (int i = 0; i < n; i++) exp_ch.push_back(ch);
  endtask

  task automatic drain(input int extra);
    wait (exp_len.size() == 0);
    repeat (extra) @(negedge clk);
  endtask

  // Monitor: pops expectations as the design produces bursts and bytes.
  always @(negedge clk) begin
    if (!rst) begin
      int g, e, meas;
      if (cpu_hold) begin
        run_len++;
        if (fetch_discard) disc++;
      end
      if (cpu_hold && !hold_prev) begin
        rises++;
        if (exp_gap.size() == 0) chk(0, "R2 unexpected burst start", cyc, -1);
        else begin
          g = exp_gap.pop_front();
          if (seen) begin
            meas = cyc - last_strb;
            if (g > 0) chk(meas == g, "R10 exact gap", meas, g);
            else chk(meas >= gap_lat, "R10 minimum gap", meas, gap_lat);
          end
        end
        chk(bus_grant, "R4 grant rises with hold", int'(bus_grant), 1);
      end
      if (xfer_strobe) begin
        run_strb++;
        if (run_strb == 1) chk(run_len == START + 1, "R4 first strobe offset", run_len, START + 1);
        if (exp_ch.size() == 0) chk(0, "R5 unexpected strobe", int'(chan_sel), -1);
        else begin
          e = exp_ch.pop_front();
          chk(int'(chan_sel) == e, "R6 channel order", int'(chan_sel), e);
        end
        last_strb = cyc;
        gap_lat = gclamp(int'(min_gap));
        seen = 1;
      end
      if (!cpu_hold && hold_prev) begin
        e = (exp_len.size() == 0) ? -1 : exp_len.pop_front();
        chk(run_len == e, "R5 R7 R8 burst length", run_len, e);
        chk(disc == FETCH, "R4 discarded fetch cycles", disc, FETCH);
        chk(cpu_refetch, "R9 refetch pulse", int'(cpu_refetch), 1);
        chk(cyc - last_strb == 3, "R9 tail length", cyc - last_strb, 3);
        run_len = 0; disc = 0; run_strb = 0;
      end
      hold_prev = cpu_hold;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (80000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired R1 actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    int r0;
    for (int i = 0; i < NCH; i++) rem[i] = 0;
    repeat (3) @(negedge clk);
    chk({bus_grant, cpu_hold, xfer_strobe, fetch_discard, cpu_refetch, irq_go} == 6'b0,
        "R1 outputs in reset", int'({bus_grant, cpu_hold, xfer_strobe}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({bus_grant, cpu_hold, xfer_strobe, fetch_discard, cpu_refetch, irq_go} == 6'b0,
        "R1 outputs after reset", int'({bus_grant, cpu_hold, xfer_strobe}), 0);

    // Long backlog on one channel: size cap, exact gap, drained end (R8 R10).
    push_burst(15, 0); push_burst(15, 64); push_burst(11, 64);
    push_ch(1, 20);
    rem[1] = 20;
    drain(80);

    // Processor above DMA: blocked; interrupt goes first until unblocked (R2 R3).
    cpu_prio = 2'd3; dma_prio = 2'd2;
    rem[0] = 3;
    r0 = rises;
    repeat (100) @(negedge clk);
    chk(rises == r0, "R2 blocked while cpu above dma", rises - r0, 0);
    irq_pending = 1'b1;
    #1 chk(irq_go, "R3 irq taken while dma blocked", int'(irq_go), 1);
    @(negedge clk);
    push_burst(10, 0); push_ch(0, 3);
    cpu_prio = 2'd2;
    #1 chk(!irq_go, "R3 dma wins over pending irq", int'(irq_go), 0);
    drain(2);
    #1 chk(irq_go, "R3 irq served after burst", int'(irq_go), 1);
    irq_pending = 1'b0;
    repeat (80) @(negedge clk);

    // DMA level 0 only at processor level 0 (R2).
    cpu_prio = 2'd1; dma_prio = 2'd0;
    rem[2] = 2;
    r0 = rises;
    repeat (50) @(negedge clk);
    chk(rises == r0, "R2 level 0 dma blocked at cpu 1", rises - r0, 0);
    push_burst(9, 0); push_ch(2, 2);
    cpu_prio = 2'd0;
    drain(80);

    // DMA level 3 runs even at processor level 3 (R2).
    cpu_prio = 2'd3; dma_prio = 2'd3;
    push_burst(9, 0); push_ch(3, 2);
    rem[3] = 2;
    drain(80);

    // Two channels: lowest first, one dead cycle on switch (R6 R7).
    cpu_prio = 2'd0; dma_prio = 2'd2;
    push_burst(13, 0); push_ch(0, 3); push_ch(2, 2);
    rem[0] = 3; rem[2] = 2;
    drain(80);

    // Clamp low ends: length 0 acts as 1, gap 5 acts as 12 (R8 R10).
    max_burst = 7'd0; min_gap = 10'd5;
    push_burst(8, 0); push_burst(8, 12); push_ch(0, 2);
    rem[0] = 2;
    drain(20);

    // Clamp high ends: length 100 acts as 64, gap 1000 acts as 512 (R8 R10).
    max_burst = 7'd100; min_gap = 10'd1000;
    push_burst(71, 0); push_burst(13, 512); push_ch(3, 70);
    rem[3] = 70;
    drain(20);
    chk(exp_ch.size() == 0, "R5 all bytes strobed", exp_ch.size(), 0);

    finish_run();
  end
endmodule